// File: doc/BRIEF.md
# Phase-Aligned Clock Post-Divider

This block sits behind the oscillator stage of a PLL and produces the output clocks. A main divider divides the oscillator clock by a power of two chosen by a two-bit select. Each divided clock has a 50% duty cycle. A bypass bit sends the raw oscillator clock to the main output instead. A phase-enable bit starts a set of auxiliary dividers. They use the same ratio as the main divider, and they feed the additional phase outputs. The analog phase offset of those clocks is applied outside this block.

The auxiliary dividers count freely from the moment they are enabled. Their phase relation to the main output is therefore arbitrary until the PLL reports lock. The lock input is synchronized into the oscillator domain. Once it rises, every enabled auxiliary counter is reloaded together with the main counter at the next main terminal count. A power-down bit holds every divider cleared, forces all outputs low and drives the lock output low.

Top module: `phase_post_divider`

## Requirements
- R1: With bypass off, the main output has a period of 2, 4, 8 or 16 oscillator cycles for select values 00, 01, 10 and 11, with 50% duty. After its counter restarts, the output is low for the first half of each period.
- R2: A new select value is adopted only when the current period ends (terminal count). The period in progress completes at the old ratio.
- R3: With the bypass bit at 1 and power-down at 0, the main output equals the oscillator clock.
- R4: With phase-enable at 0, every auxiliary output is low and its counter is held cleared.
- R5: An enabled auxiliary divider counts at the main ratio, starting from zero on the first cycle after enable. Before lock it keeps whatever offset this gives relative to the main output.
- R6: The lock output follows the lock input through a two-flop synchronizer. It rises on the second oscillator edge after the input rises.
- R7: At the first main terminal count after each rise of the synchronized lock, every enabled auxiliary counter is reloaded with the main counter. From then on the auxiliary outputs equal the main divided output.
- R8: While power-down is 1, the main output, all auxiliary outputs and the lock output are low, and all counters are cleared. This holds even with bypass set.
- R9: After power-down clears with the lock input held high, the lock output rises on the second oscillator edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock, main phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Lock indication from the phase detector, asynchronous |
| div_sel | input | SEL_W (2) | Divide select: 00=/2, 01=/4, 10=/8, 11=/16 |
| bypass_en | input | 1 | 1: main output is the raw oscillator clock |
| phase_en | input | 1 | 1: auxiliary phase dividers run |
| pwr_dn | input | 1 | 1: dividers cleared, outputs and lock low |
| clk_main_o | output | 1 | Main output clock |
| clk_aux_o | output | NUM_AUX (2) | Auxiliary phase output clocks |
| lock_o | output | 1 | Synchronized lock indication |

## Verification
The hardest state to reach from the ports is an auxiliary divider that runs out of step with the main divider and is then pulled into step by lock. The bench reaches it in three steps. First it clears everything with power-down and releases the main divider. It then enables the auxiliary dividers one cycle later, which gives a known offset of one count, and confirms at the outputs that the auxiliary and main clocks differ. Only then does it raise lock, and it checks that the outputs become identical after the first terminal count. The whole sequence runs a second time after a power-down so that realignment is shown for a second lock assertion.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  // full divide ratio for a select code: 2 << sel
  function automatic int ratio_of(input int sel);
    return 2 << sel;
  endfunction

  // last counter value of one period
  function automatic int last_count(input int sel);
    return ratio_of(sel) - 1;
  endfunction
endpackage

// File: rtl/pdiv_counter.sv
module pdiv_counter #(
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   restart,
  input  logic [SEL_W-1:0]       sel_in,
  output logic [(1<<SEL_W)-1:0]  cnt_o,
  output logic                   tc_o,
  output logic                   div_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;

  assign tc_o  = (cnt_q == CNT_W'(pdiv_pkg::last_count(int'(sel_q))));
  assign div_o = cnt_q[sel_q];
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (clear || restart || tc_o) begin
      cnt_q <= '0;
      sel_q <= sel_in;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(pdiv_pkg::last_count(int'(sel_q))));

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear || restart || tc_o) |=> $stable(sel_q));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && !div_o);
endmodule

// File: rtl/pdiv_lock_align.sv
module pdiv_lock_align (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic lock_in,
  input  logic main_tc,
  output logic lock_o,
  output logic align_o
);
  logic sync1_q, sync2_q, prev_q, armed_q;
  logic lock_rise;

  assign lock_rise = sync2_q && !prev_q;
  assign align_o   = armed_q && main_tc;
  assign lock_o    = sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (clear) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sync1_q <= lock_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (lock_rise)     armed_q <= 1'b1;
      else if (align_o)  armed_q <= 1'b0;
    end
  end

  p_lock_low_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !lock_o);

  p_align_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_o |-> lock_o);

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(sync1_q));
endmodule

// File: rtl/phase_post_divider.sv
module phase_post_divider #(
  parameter int SEL_W   = 2,
  parameter int NUM_AUX = 2
) (
  input  logic               osc_clk,
  input  logic               rst_n,
  input  logic               lock_in,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               bypass_en,
  input  logic               phase_en,
  input  logic               pwr_dn,
  output logic               clk_main_o,
  output logic [NUM_AUX-1:0] clk_aux_o,
  output logic               lock_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic             main_tc, main_div, align_pulse, aux_clear;
  logic [CNT_W-1:0] main_cnt;

  pdiv_counter #(.SEL_W(SEL_W)) u_main (
    .clk(osc_clk), .rst_n(rst_n), .clear(pwr_dn), .restart(1'b0),
    .sel_in(div_sel), .cnt_o(main_cnt), .tc_o(main_tc), .div_o(main_div)
  );

  pdiv_lock_align u_lock (
    .clk(osc_clk), .rst_n(rst_n), .clear(pwr_dn), .lock_in(lock_in),
    .main_tc(main_tc), .lock_o(lock_o), .align_o(align_pulse)
  );

  assign aux_clear  = pwr_dn || !phase_en;
  assign clk_main_o = pwr_dn ? 1'b0 : (bypass_en ? osc_clk : main_div);

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
    logic [CNT_W-1:0] aux_cnt;
    logic             aux_tc;

    pdiv_counter #(.SEL_W(SEL_W)) u_aux (
      .clk(osc_clk), .rst_n(rst_n), .clear(aux_clear), .restart(align_pulse),
      .sel_in(div_sel), .cnt_o(aux_cnt), .tc_o(aux_tc), .div_o(clk_aux_o[g])
    );

    p_aux_low_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !phase_en |=> !clk_aux_o[g]);

    p_aligned_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (align_pulse && phase_en && !pwr_dn) |=> (aux_cnt == main_cnt));

    p_aux_wrap_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (aux_tc && phase_en && !pwr_dn) |=> (aux_cnt == '0));
  end

  p_outputs_low_pd_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
    pwr_dn |=> (!main_div && clk_aux_o == '0 && !lock_o));
endmodule

// File: tb/phase_post_divider_bench.sv
module phase_post_divider_bench;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_in = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       bypass_en = 1'b0;
  logic       phase_en = 1'b0;
  logic       pwr_dn = 1'b1;
  logic       clk_main_o;
  logic [1:0] clk_aux_o;
  logic       lock_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  always #10 osc_clk = ~osc_clk;

  phase_post_divider u_phase_post_divider (
    .osc_clk(osc_clk), .rst_n(rst_n), .lock_in(lock_in), .div_sel(div_sel),
    .bypass_en(bypass_en), .phase_en(phase_en), .pwr_dn(pwr_dn),
    .clk_main_o(clk_main_o), .clk_aux_o(clk_aux_o), .lock_o(lock_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge osc_clk);
    #5;
  endtask

  // clear with power-down, set select, release; next step() is sample k=1
  task automatic restart_main(input logic [1:0] sel);
    @(negedge osc_clk);
    pwr_dn = 1'b1; div_sel = sel;
    step(); step();
    @(negedge osc_clk);
    pwr_dn = 1'b0;
  endtask

  task automatic t_reset();
    step();
    check(clk_main_o == 0 && clk_aux_o == 0 && lock_o == 0, "R8 reset state",
          {clk_main_o, clk_aux_o, lock_o}, 0);
  endtask

  task automatic t_ratios();
    for (int s = 0; s < 4; s++) begin
      int n = 2 << s;
      int bad = 0;
      restart_main(2'(s));
      for (int k = 1; k <= 2 * n; k++) begin
        step();
        if (clk_main_o != ((k % n) >= n / 2)) bad++;
      end
      check(bad == 0, $sformatf("R1 ratio sel=%0d", s), bad, 0);
    end
  endtask

  task automatic t_sel_change();
    int exp [4:10] = '{1, 1, 1, 1, 0, 1, 0};
    int bad = 0;
    restart_main(2'd2);
    for (int k = 1; k <= 3; k++) step();
    @(negedge osc_clk);
    div_sel = 2'd0;
    for (int k = 4; k <= 10; k++) begin
      step();
      if (clk_main_o != exp[k]) bad++;
    end
    check(bad == 0, "R2 select waits for terminal count", bad, 0);
  endtask

  task automatic t_bypass();
    int bad = 0;
    restart_main(2'd3);
    @(negedge osc_clk);
    bypass_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      if (clk_main_o != 1'b1) bad++;
      @(negedge osc_clk); #5;
      if (clk_main_o != 1'b0) bad++;
    end
    check(bad == 0, "R3 bypass follows oscillator", bad, 0);
    @(negedge osc_clk);
    bypass_en = 1'b0;
  endtask

  task automatic t_aux_off();
    int bad = 0;
    int toggles = 0;
    logic last;
    restart_main(2'd0);
    phase_en = 1'b0;
    step();
    last = clk_main_o;
    for (int k = 0; k < 16; k++) begin
      step();
      if (clk_aux_o != 2'b00) bad++;
      if (clk_main_o != last) toggles++;
      last = clk_main_o;
    end
    check(bad == 0 && toggles > 0, "R4 aux low when disabled", bad, 0);
  endtask

  task automatic t_align(input string pass);
    int bad;
    lock_in = 1'b0;
    phase_en = 1'b0;
    restart_main(2'd1);
    step();                       // k=1
    @(negedge osc_clk);
    phase_en = 1'b1;
    step();                       // k=2: main cnt 2, aux cnt 1
    check(clk_main_o == 1 && clk_aux_o == 2'b00, {"R5 unaligned before lock ", pass},
          {clk_main_o, clk_aux_o}, 4);
    bad = 0;
    for (int k = 3; k <= 10; k++) begin
      step();
      if (clk_aux_o[0] != (((k - 1) % 4) >= 2) || clk_aux_o[1] != clk_aux_o[0]) bad++;
    end
    check(bad == 0, {"R5 aux free-running ratio ", pass}, bad, 0);
    @(negedge osc_clk);
    lock_in = 1'b1;
    step();
    check(lock_o == 0, {"R6 lock after one edge ", pass}, lock_o, 0);
    step();
    check(lock_o == 1, {"R6 lock after two edges ", pass}, lock_o, 1);
    for (int k = 13; k <= 16; k++) step();
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      step();
      if (clk_aux_o[0] != clk_main_o || clk_aux_o[1] != clk_main_o) bad++;
    end
    check(bad == 0, {"R7 aligned after lock ", pass}, bad, 0);
  endtask

  task automatic t_power_down();
    int bad = 0;
    lock_in = 1'b1;
    @(negedge osc_clk);
    pwr_dn = 1'b1;
    bypass_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      if (lock_o || clk_main_o || clk_aux_o != 2'b00) bad++;
      @(negedge osc_clk); #5;
      if (lock_o || clk_main_o || clk_aux_o != 2'b00) bad++;
    end
    check(bad == 0, "R8 power-down outputs low", bad, 0);
    @(negedge osc_clk);
    bypass_en = 1'b0;
    pwr_dn = 1'b0;
    step();
    check(lock_o == 0, "R9 lock low one edge after release", lock_o, 0);
    step();
    check(lock_o == 1, "R9 lock high two edges after release", lock_o, 1);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    @(negedge osc_clk);
    rst_n = 1'b1;
    t_ratios();
    t_sel_change();
    t_bypass();
    t_aux_off();
    t_align("first");
    t_power_down();
    t_align("second");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule